// File: doc/BRIEF.md
# Strap-Configured Serial Flash Read Engine

This block is the serial flash reader used by boot logic to fetch bytes from an external SPI flash. A request carries a 24-bit start address, a byte count, a transfer width (one or two data lines) and a clock polarity choice. The block asserts chip select and sends an 8-bit read opcode followed by the address, most significant bit first. It then returns each received byte with a one-cycle valid strobe, and it releases chip select once the last byte has arrived.

The serial data-out line shares its pad with a speed strap. While reset is held, the block leaves the pad undriven and asks for a weak pull-down. On the first clock edge after reset is released, it captures the pad level as the clock-rate choice and takes the pad over as serial data out. The captured bit can be read at a fixed control-register address. A low strap gives the slow rate, with the serial clock at one quarter of the system clock. A high strap gives the fast rate, with the serial clock at one half of the system clock.

Top module: `flash_rd_strap`

## Requirements
- R1: While rst_ni is low, pad_oe_o is 0, pad_pd_o is 1, cs_no is 1 and sck_o is 0.
- R2: After reset is released, pad_pd_o is 0 from the first clock edge onward, and pad_oe_o is 1 whenever no transfer is in progress.
- R3: When ctl_addr_i equals 0x2400, ctl_rdata_o returns the speed bit at bit 1 and zeros in all other bits. The speed bit reads 1 while reset is held, so the register reads 0x02. At the first clock edge after reset it takes the value of pad_i. Any other address reads 0x00.
- R4: With speed bit 1, one sck_o period during a transfer lasts 2 system clocks. With speed bit 0, it lasts 4 system clocks.
- R5: A request accepted while idle pulls cs_no low and shifts 32 bits out on pad_o, MSB first, each valid at a rising edge of sck_o. The first 8 bits are the opcode, 0x03 for a single-line read or 0x3B for a dual-line read. The remaining 24 bits are addr_i.
- R6: In single-line mode, each data byte is taken from io1_i over 8 rising edges of sck_o, MSB first.
- R7: In dual-line mode, each data byte is taken over 4 rising edges of sck_o. At each edge, io1_i supplies the higher bit of the pair and pad_i supplies the lower bit, starting with bits 7:6. pad_oe_o is 0 throughout the dual data phase and stays 1 in single-line mode.
- R8: While idle, sck_o rests at the level of mode3_i, sampled one cycle earlier: 0 for mode 0 and 1 for mode 3. After a transfer it returns to the idle level of the mode it was started with. In both modes, data is sampled on the rising edge.
- R9: A transfer delivers exactly len_i bytes, each with a one-cycle rvalid_o pulse and the byte on rdata_o. A len_i of 0 means 256 bytes. A single done_o pulse coincides with cs_no returning high, and req_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a read (taken only while idle) |
| addr_i | input | 24 | Flash start address |
| len_i | input | 8 | Byte count (0 means 256) |
| dual_i | input | 1 | 1: dual-line data phase |
| mode3_i | input | 1 | 1: clock idles high, 0: idles low |
| busy_o | output | 1 | Transfer in progress |
| rdata_o | output | 8 | Received byte |
| rvalid_o | output | 1 | rdata_o valid strobe |
| done_o | output | 1 | Transfer finished strobe |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| pad_i | input | 1 | Shared pad level (strap at reset, IO0 in dual reads) |
| pad_o | output | 1 | Serial data out onto shared pad |
| pad_oe_o | output | 1 | Shared pad output enable |
| pad_pd_o | output | 1 | Shared pad weak pull-down enable |
| io1_i | input | 1 | Serial data in (IO1) |
| ctl_addr_i | input | 16 | Control register read address |
| ctl_rdata_o | output | 8 | Control register read data |

## Verification
A flash model in the bench returns bytes that depend on the address. The bench runs transfers in all four combinations of line width and clock polarity, under both strap values. This separates bit-order faults in the opcode and address from errors in the pairing of IO1 and IO0 in dual reads. It also shows whether the idle clock level follows the selected mode. Random start addresses and lengths from 1 to 6 bytes test byte counting and the opcode choice. A new request issued in the middle of a transfer shows whether that request is ignored. Resets with the strap low and high show whether the clock period and the register bit follow the captured level.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam logic [7:0]  OP_READ_1 = 8'h03;
  localparam logic [7:0]  OP_READ_2 = 8'h3B;
  localparam logic [15:0] CTL_REG_ADDR = 16'h2400;
  localparam int unsigned SPD_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_END
  } rd_state_e;
endpackage

// File: rtl/flash_strap_cap.sv
module flash_strap_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  output logic speed_o,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      speed_o <= 1'b1;
    end else if (!done_o) begin
      done_o  <= 1'b1;
      speed_o <= pad_i;
    end
  end
endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fast_i,
  output logic tick_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= 1'b0;
    else if (!en_i) div_q <= 1'b0;
    else            div_q <= ~div_q;
  end

  // fast: every cycle, slow: every other cycle
  assign tick_o = en_i & (fast_i | div_q);
endmodule

// File: rtl/flash_rd_engine.sv
module flash_rd_engine
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 8,
  parameter logic [7:0]  OP_1   = OP_READ_1,
  parameter logic [7:0]  OP_2   = OP_READ_2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              dual_i,
  input  logic              mode3_i,
  input  logic              io1_i,
  input  logic              io0_i,
  output logic              busy_o,
  output logic              cs_no,
  output logic              sck_o,
  output logic              io0_o,
  output logic              io0_oe_o,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              done_o
);
  localparam int unsigned FRAME_W = 8 + ADDR_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  rd_state_e         state_q;
  logic [FRAME_W-1:0] sh_out_q;
  logic [6:0]         sh_in_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [2:0]         bits_q;
  logic [LEN_W-1:0]   left_q;
  logic               phase_q, first_q, dual_q, mode_q;
  logic [7:0]         nxt;
  logic [2:0]         last_bit;

  assign nxt      = dual_q ? {sh_in_q[5:0], io1_i, io0_i} : {sh_in_q, io1_i};
  assign last_bit = dual_q ? 3'd3 : 3'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_out_q <= '0;
      sh_in_q  <= '0;
      cnt_q    <= '0;
      bits_q   <= '0;
      left_q   <= '0;
      phase_q  <= 1'b0;
      first_q  <= 1'b1;
      dual_q   <= 1'b0;
      mode_q   <= 1'b0;
      cs_no    <= 1'b1;
      sck_o    <= 1'b0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      rvalid_o <= 1'b0;
      done_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          sck_o <= mode3_i;
          if (en_i && req_i) begin
            state_q  <= ST_CMD;
            cs_no    <= 1'b0;
            sh_out_q <= {dual_i ? OP_2 : OP_1, addr_i};
            mode_q   <= mode3_i;
            dual_q   <= dual_i;
            left_q   <= len_i;
            cnt_q    <= '0;
            bits_q   <= '0;
            phase_q  <= 1'b0;
            first_q  <= 1'b1;
          end
        end
        ST_CMD, ST_DATA: begin
          if (tick_i) begin
            if (!phase_q) begin
              // falling half: present next output bit
              sck_o   <= 1'b0;
              phase_q <= 1'b1;
              first_q <= 1'b0;
              if (!first_q && state_q == ST_CMD)
                sh_out_q <= {sh_out_q[FRAME_W-2:0], 1'b0};
            end else begin
              // rising half: sample
              sck_o   <= 1'b1;
              phase_q <= 1'b0;
              if (state_q == ST_CMD) begin
                if (cnt_q == CNT_W'(FRAME_W - 1)) begin
                  state_q <= ST_DATA;
                  cnt_q   <= '0;
                end else begin
                  cnt_q <= cnt_q + 1'b1;
                end
              end else begin
                sh_in_q <= nxt[6:0];
                if (bits_q == last_bit) begin
                  bits_q   <= '0;
                  rdata_o  <= nxt;
                  rvalid_o <= 1'b1;
                  left_q   <= left_q - 1'b1;
                  if (left_q == LEN_W'(1)) state_q <= ST_END;
                end else begin
                  bits_q <= bits_q + 1'b1;
                end
              end
            end
          end
        end
        ST_END: begin
          if (tick_i) begin
            sck_o   <= mode_q;
            cs_no   <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign io0_o    = sh_out_q[FRAME_W-1];
  assign io0_oe_o = !(state_q == ST_DATA && dual_q);
endmodule

// File: rtl/flash_rd_strap.sv
module flash_rd_strap
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned LEN_W    = 8,
  parameter logic [7:0]  OP_1     = OP_READ_1,
  parameter logic [7:0]  OP_2     = OP_READ_2,
  parameter logic [15:0] CTL_ADDR = CTL_REG_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              dual_i,
  input  logic              mode3_i,
  output logic              busy_o,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              done_o,
  output logic              cs_no,
  output logic              sck_o,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              pad_pd_o,
  input  logic              io1_i,
  input  logic [15:0]       ctl_addr_i,
  output logic [7:0]        ctl_rdata_o
);
  logic speed_q, strap_done, tick, io0_oe;

  flash_strap_cap u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_i),
    .speed_o(speed_q),
    .done_o (strap_done)
  );

  flash_tick_gen u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy_o),
    .fast_i(speed_q),
    .tick_o(tick)
  );

  flash_rd_engine #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .OP_1  (OP_1),
    .OP_2  (OP_2)
  ) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (strap_done),
    .tick_i  (tick),
    .req_i   (req_i),
    .addr_i  (addr_i),
    .len_i   (len_i),
    .dual_i  (dual_i),
    .mode3_i (mode3_i),
    .io1_i   (io1_i),
    .io0_i   (pad_i),
    .busy_o  (busy_o),
    .cs_no   (cs_no),
    .sck_o   (sck_o),
    .io0_o   (pad_o),
    .io0_oe_o(io0_oe),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o),
    .done_o  (done_o)
  );

  // pad stays an input with pull-down until the strap is captured
  assign pad_oe_o    = strap_done & io0_oe;
  assign pad_pd_o    = ~strap_done;
  assign ctl_rdata_o = (ctl_addr_i == CTL_ADDR) ? (8'(speed_q) << SPD_BIT) : 8'h00;
endmodule

// File: rtl/flash_rd_strap_chk.sv
module flash_rd_strap_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pad_oe_o,
  input logic pad_pd_o,
  input logic cs_no,
  input logic sck_o,
  input logic busy_o,
  input logic rvalid_o,
  input logic done_o,
  input logic speed_q,
  input logic strap_done
);
  AST_RESET_PAD: assert property (@(posedge clk_i)
    !rst_ni |-> (!pad_oe_o && pad_pd_o && cs_no && !sck_o)); // R1

  AST_IDLE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done && !busy_o) |-> (pad_oe_o && !pad_pd_o)); // R2

  AST_SPEED_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done && $past(strap_done)) |-> $stable(speed_q)); // R3

  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no); // R5

  AST_RVALID_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !cs_no); // R9

  AST_DONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o); // R9
endmodule

bind flash_rd_strap flash_rd_strap_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pad_oe_o  (pad_oe_o),
  .pad_pd_o  (pad_pd_o),
  .cs_no     (cs_no),
  .sck_o     (sck_o),
  .busy_o    (busy_o),
  .rvalid_o  (rvalid_o),
  .done_o    (done_o),
  .speed_q   (speed_q),
  .strap_done(strap_done)
);

// File: tb/flash_rd_strap_test.sv
`timescale 1ns/1ps
module flash_rd_strap_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        req_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  len_i = 8'd1;
  logic        dual_i = 1'b0;
  logic        mode3_i = 1'b0;
  logic        busy_o, rvalid_o, done_o, cs_no, sck_o;
  logic [7:0]  rdata_o, ctl_rdata_o;
  logic        pad_i, pad_o, pad_oe_o, pad_pd_o;
  logic        io1_i;
  logic [15:0] ctl_addr_i = 16'h2400;

  logic strap = 1'b0;
  logic s_io0 = 1'b0, s_io1 = 1'b0, s_drv = 1'b0;
  logic cur_dual = 1'b0;
  int   s_cnt = 0;
  logic [31:0] s_cmd = '0;
  time  t1 = 0, t2 = 0;
  int   k, j;
  logic [7:0] sb;

  logic [7:0] got [0:15];
  int   got_n = 0, done_cnt = 0, cur_total = 0, oe_bad = 0;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  assign io1_i = s_io1;
  assign pad_i = pad_oe_o ? pad_o : (s_drv ? s_io0 : strap);

  flash_rd_strap uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .len_i(len_i),
    .dual_i(dual_i), .mode3_i(mode3_i), .busy_o(busy_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .done_o(done_o), .cs_no(cs_no), .sck_o(sck_o),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o), .pad_pd_o(pad_pd_o),
    .io1_i(io1_i), .ctl_addr_i(ctl_addr_i), .ctl_rdata_o(ctl_rdata_o)
  );

  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model
  always @(negedge cs_no) begin s_cnt = 0; end
  always @(posedge cs_no) begin s_drv = 1'b0; end
  always @(posedge sck_o) begin
    if (!cs_no) begin
      if (s_cnt < 32) s_cmd = {s_cmd[30:0], pad_o};
      s_cnt++;
      if (s_cnt == 1) t1 = $time;
      if (s_cnt == 2) t2 = $time;
    end
  end
  always @(negedge sck_o) begin
    if (!cs_no && s_cnt >= 32) begin
      k = s_cnt - 32;
      if (cur_dual) begin
        sb = exp_byte(s_cmd[23:0] + 24'(k / 4));
        j = k % 4;
        s_io1 = sb[7 - 2*j];
        s_io0 = sb[6 - 2*j];
        s_drv = 1'b1;
      end else begin
        sb = exp_byte(s_cmd[23:0] + 24'(k / 8));
        s_io1 = sb[7 - (k % 8)];
      end
    end
  end

  // monitors
  always @(negedge clk) begin
    if (rvalid_o) begin
      if (got_n < 16) got[got_n] = rdata_o;
      got_n++;
    end
    if (done_o) done_cnt++;
    if (!cs_no && s_cnt >= 33 && s_cnt < cur_total && (pad_oe_o == cur_dual)) oe_bad++;
  end

  task automatic do_reset(input logic s);
    strap = s;
    rst_ni = 1'b0;
    ctl_addr_i = 16'h2400;
    repeat (3) @(negedge clk);
    chk(!pad_oe_o && pad_pd_o, "R1 pad in reset", {pad_oe_o, pad_pd_o}, 2'b01);
    chk(cs_no && !sck_o, "R1 cs/sck in reset", {cs_no, sck_o}, 2'b10);
    chk(ctl_rdata_o == 8'h02, "R3 reset value", ctl_rdata_o, 8'h02);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pad_oe_o && !pad_pd_o, "R2 pad after release", {pad_oe_o, pad_pd_o}, 2'b10);
    chk(ctl_rdata_o == {6'b0, s, 1'b0}, "R3 latched speed", ctl_rdata_o, {6'b0, s, 1'b0});
    ctl_addr_i = 16'h2401;
    #1;
    chk(ctl_rdata_o == 8'h00, "R3 other address", ctl_rdata_o, 8'h00);
    ctl_addr_i = 16'h2400;
  endtask

  task automatic run(input logic [23:0] a, input int n, input bit d, input bit m3, input bit poke);
    int guard;
    @(negedge clk);
    mode3_i = m3;
    repeat (2) @(negedge clk);
    chk(sck_o == m3, "R8 idle level", sck_o, m3);
    got_n = 0; done_cnt = 0; oe_bad = 0;
    cur_dual = d;
    cur_total = 32 + n * (d ? 4 : 8);
    req_i = 1'b1; addr_i = a; len_i = 8'(n); dual_i = d;
    @(negedge clk);
    req_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_i = 1'b1; addr_i = ~a; dual_i = !d;
      @(negedge clk);
      req_i = 1'b0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(s_cmd[31:24] == (d ? 8'h3B : 8'h03), "R5 opcode", s_cmd[31:24], d ? 8'h3B : 8'h03);
    chk(s_cmd[23:0] == a, "R5 address", s_cmd[23:0], a);
    chk(got_n == n, "R9 byte count", got_n, n);
    for (int i = 0; i < n && i < 16; i++) begin
      if (d) chk(got[i] == exp_byte(a + 24'(i)), "R7 dual byte", got[i], exp_byte(a + 24'(i)));
      else   chk(got[i] == exp_byte(a + 24'(i)), "R6 single byte", got[i], exp_byte(a + 24'(i)));
    end
    chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
    chk(oe_bad == 0, "R7 pad direction in data phase", oe_bad, 0);
    chk((t2 - t1) == (strap ? 20 : 40), "R4 sck period", 32'(t2 - t1), strap ? 20 : 40);
    chk(cs_no && sck_o == m3 && !busy_o, "R8 rest after transfer", {cs_no, sck_o, busy_o}, {1'b1, m3, 1'b0});
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #1;
    do_reset(1'b0);
    run(24'h000000, 1, 1'b0, 1'b0, 1'b0);
    run(24'hFFFFFE, 4, 1'b1, 1'b1, 1'b0);
    run(24'h123456, 3, 1'b0, 1'b1, 1'b1);
    run(24'hA5C3F0, 5, 1'b1, 1'b0, 1'b1);
    for (int t = 0; t < 10; t++)
      run(24'($urandom), 1 + ($urandom % 6), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    do_reset(1'b1);
    run(24'h800001, 2, 1'b0, 1'b0, 1'b0);
    run(24'h7FFFFF, 4, 1'b1, 1'b1, 1'b1);
    for (int t = 0; t < 10; t++)
      run(24'($urandom), 1 + ($urandom % 6), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    do_reset(1'b0);
    run(24'h00F00F, 2, 1'b1, 1'b0, 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule